// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves branches for a 32-bit core. A branch is controlled by a five-bit option field and a five-bit field that selects one condition bit. Each issued instruction comes with the current PC, the 32-bit condition register and the present link and count register values. The unit decides whether the branch is taken and works out the next PC. It also produces write-backs for the count register (a decrement) and for the link register (the return address).

The unit handles four branch shapes. The first is an unconditional branch with a 24-bit word displacement, either PC-relative or absolute. The second is a conditional branch with a 14-bit word displacement, either PC-relative or absolute. The third and fourth are conditional branches whose target comes from the link register or from the count register. A conditional branch is taken only when two tests both pass. One test is an optional counter test that decrements the count register as a side effect. The other is an optional test of one condition-register bit.

All results are registered. They appear one clock after the issue strobe, and the register-file owner applies the write enables on that cycle.

Top module: `branch_resolve`

## Requirements
- R1: While reset is held and on the first cycle after reset, `res_valid_o`, `taken_o`, `lr_we_o` and `ctr_we_o` are all low.
- R2: Primary opcode 18 (instruction bits 31:26) is an unconditional branch and is always taken. Its displacement is bits 25:2 scaled by four and sign-extended from bit 25. With bit 1 clear the target is PC plus the displacement. With bit 1 set the target is the displacement itself.
- R3: Primary opcode 16 is a conditional immediate branch. Its displacement is bits 15:2 scaled by four and sign-extended from bit 15. Bit 1 selects absolute or PC-relative in the same way as in R2.
- R4: The option field is bits 25:21. When option bit 2 is set, the counter test passes and no count write-back is raised.
- R5: When option bit 2 is clear on a conditional form, `ctr_we_o` is raised with `ctr_wd_o` = count - 1 (modulo 2^32), whether or not the branch is taken. The counter test passes when the new count is nonzero and option bit 1 is clear, or when the new count is zero and option bit 1 is set.
- R6: When option bit 4 is set, the condition test passes. Otherwise the select field (bits 20:16) picks condition-register bit (31 - select), and that bit must equal option bit 3.
- R7: A conditional form is taken only when both tests pass. A branch that is not taken yields next PC = PC + 4.
- R8: Primary opcode 19 with extended opcode 16 (bits 10:1) branches to the link register, and with extended opcode 528 it branches to the count register. In both cases the low two bits of the target are cleared, and the conditions are the same as in R4 to R7.
- R9: When bit 0 (link) is set on any recognised branch, `lr_we_o` is raised with `lr_wd_o` = PC + 4, whether or not the branch is taken.
- R10: Any other opcode, or opcode 19 with any other extended opcode, yields a result that is not taken, with next PC = PC + 4 and no write-back.
- R11: `res_valid_o` is high exactly on the cycle after an issue, and back-to-back issues give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction presented this cycle |
| insn_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| cr_i | input | 32 | Condition register |
| lr_i | input | 32 | Current link register |
| ctr_i | input | 32 | Current count register |
| res_valid_o | output | 1 | Result valid (one cycle after issue) |
| taken_o | output | 1 | Branch taken |
| npc_o | output | 32 | Next PC |
| lr_we_o | output | 1 | Link register write enable |
| lr_wd_o | output | 32 | Link register write data |
| ctr_we_o | output | 1 | Count register write enable |
| ctr_wd_o | output | 32 | Count register write data |

## Verification
The bench targets the sign-extension boundaries: an all-ones displacement, the top displacement bit alone, and absolute mode with a negative value. A unit that extends from the wrong bit would send these to far addresses. It checks the counter test at count 1 and at count 0. A unit that tests the old count rather than the decremented one, or that does not wrap at zero, would flip the taken decision there. It sweeps the condition select across both ends of the register. A reversed bit index would read the wrong bit. It also confirms that the decrement and the link write still happen on branches that are not taken, and that unrecognised opcodes cause no write and no redirect.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned XO_W    = 10;
  localparam int unsigned FLD_W   = 5;
  localparam int unsigned LI_W    = 24;
  localparam int unsigned BD_W    = 14;
  localparam int unsigned STEP    = 4;

  localparam logic [OPC_W-1:0] OPC_UNCOND = 6'd18;
  localparam logic [OPC_W-1:0] OPC_CONDI  = 6'd16;
  localparam logic [OPC_W-1:0] OPC_XL     = 6'd19;
  localparam logic [XO_W-1:0]  XO_TO_LR   = 10'd16;
  localparam logic [XO_W-1:0]  XO_TO_CTR  = 10'd528;

  typedef enum logic [2:0] {
    BK_NONE,
    BK_UNCOND,
    BK_COND_IMM,
    BK_COND_LR,
    BK_COND_CTR
  } br_kind_e;

  typedef struct packed {
    br_kind_e           kind;
    logic [FLD_W-1:0]   opt;
    logic [FLD_W-1:0]   sel;
    logic               abs_mode;
    logic               link;
    logic [LI_W-1:0]    li;
    logic [BD_W-1:0]    bd;
  } br_fields_t;

  function automatic logic [XLEN-1:0] ext_long(input logic [LI_W-1:0] f);
    return {{(XLEN-LI_W-2){f[LI_W-1]}}, f, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] ext_short(input logic [BD_W-1:0] f);
    return {{(XLEN-BD_W-2){f[BD_W-1]}}, f, 2'b00};
  endfunction

  function automatic logic ctr_test(input logic [FLD_W-1:0] opt,
                                    input logic [XLEN-1:0]  new_cnt);
    if (opt[2]) return 1'b1;
    return (new_cnt != '0) ? ~opt[1] : opt[1];
  endfunction

  function automatic logic cond_test(input logic [FLD_W-1:0] opt,
                                     input logic [FLD_W-1:0] sel,
                                     input logic [XLEN-1:0]  cr);
    logic [FLD_W-1:0] idx;
    if (opt[4]) return 1'b1;
    idx = 5'(XLEN-1) - sel;
    return cr[idx] == opt[3];
  endfunction
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
(
  input  logic [XLEN-1:0] insn,
  output br_fields_t      fields
);
  logic [OPC_W-1:0] opc;
  logic [XO_W-1:0]  xo;

  assign opc = insn[XLEN-1 -: OPC_W];
  assign xo  = insn[XO_W:1];

  always_comb begin
    fields.opt      = insn[25:21];
    fields.sel      = insn[20:16];
    fields.abs_mode = insn[1];
    fields.link     = insn[0];
    fields.li       = insn[25:2];
    fields.bd       = insn[15:2];
    fields.kind     = BK_NONE;
    if (opc == OPC_UNCOND)                         fields.kind = BK_UNCOND;
    else if (opc == OPC_CONDI)                     fields.kind = BK_COND_IMM;
    else if (opc == OPC_XL && xo == XO_TO_LR)      fields.kind = BK_COND_LR;
    else if (opc == OPC_XL && xo == XO_TO_CTR)     fields.kind = BK_COND_CTR;
  end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  logic [FLD_W-1:0] opt,
  input  logic [FLD_W-1:0] sel,
  input  logic [XLEN-1:0]  cr,
  input  logic [XLEN-1:0]  ctr,
  output logic [XLEN-1:0]  ctr_dec,
  output logic             ctr_upd,
  output logic             ctr_ok,
  output logic             cond_ok
);
  assign ctr_dec = ctr - XLEN'(1);
  assign ctr_upd = ~opt[2];
  assign ctr_ok  = ctr_test(opt, ctr_dec);
  assign cond_ok = cond_test(opt, sel, cr);
endmodule

// File: rtl/br_target.sv
module br_target
  import br_pkg::*;
(
  input  br_fields_t      fields,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] lr,
  input  logic [XLEN-1:0] ctr,
  output logic [XLEN-1:0] target
);
  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] align_mask;

  assign align_mask = ~XLEN'(3);
  assign disp = (fields.kind == BK_UNCOND) ? ext_long(fields.li)
                                           : ext_short(fields.bd);

  always_comb begin
    unique case (fields.kind)
      BK_COND_LR:  target = lr & align_mask;
      BK_COND_CTR: target = ctr & align_mask;
      BK_UNCOND, BK_COND_IMM:
        target = fields.abs_mode ? disp : pc + disp;
      default:     target = pc + XLEN'(STEP);
    endcase
  end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import br_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic [XLEN-1:0] insn_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] cr_i,
  input  logic [XLEN-1:0] lr_i,
  input  logic [XLEN-1:0] ctr_i,
  output logic            res_valid_o,
  output logic            taken_o,
  output logic [XLEN-1:0] npc_o,
  output logic            lr_we_o,
  output logic [XLEN-1:0] lr_wd_o,
  output logic            ctr_we_o,
  output logic [XLEN-1:0] ctr_wd_o
);
  br_fields_t      fields;
  logic [XLEN-1:0] ctr_dec;
  logic            ctr_upd;
  logic            ctr_pass;
  logic            cond_pass;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] seq_pc;
  logic            is_cond;
  logic            is_branch;
  logic            take_now;
  logic            ctr_wr_now;
  logic            lr_wr_now;

  br_decode u_dec (.insn(insn_i), .fields(fields));

  br_cond_eval u_eval (
    .opt    (fields.opt),
    .sel    (fields.sel),
    .cr     (cr_i),
    .ctr    (ctr_i),
    .ctr_dec(ctr_dec),
    .ctr_upd(ctr_upd),
    .ctr_ok (ctr_pass),
    .cond_ok(cond_pass)
  );

  br_target u_tgt (
    .fields(fields),
    .pc    (pc_i),
    .lr    (lr_i),
    .ctr   (ctr_i),
    .target(target)
  );

  assign seq_pc     = pc_i + XLEN'(STEP);
  assign is_cond    = (fields.kind == BK_COND_IMM) || (fields.kind == BK_COND_LR) ||
                      (fields.kind == BK_COND_CTR);
  assign is_branch  = is_cond || (fields.kind == BK_UNCOND);
  assign take_now   = (fields.kind == BK_UNCOND) || (is_cond && ctr_pass && cond_pass);
  assign ctr_wr_now = is_cond && ctr_upd;
  assign lr_wr_now  = is_branch && fields.link;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      taken_o     <= 1'b0;
      npc_o       <= '0;
      lr_we_o     <= 1'b0;
      lr_wd_o     <= '0;
      ctr_we_o    <= 1'b0;
      ctr_wd_o    <= '0;
    end else begin
      res_valid_o <= issue_i;
      taken_o     <= issue_i && take_now;
      npc_o       <= take_now ? target : seq_pc;
      lr_we_o     <= issue_i && lr_wr_now;
      lr_wd_o     <= seq_pc;
      ctr_we_o    <= issue_i && ctr_wr_now;
      ctr_wd_o    <= ctr_dec;
    end
  end
endmodule

// File: rtl/branch_resolve_checker.sv
module branch_resolve_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        issue_i,
  input logic [31:0] insn_i,
  input logic [31:0] pc_i,
  input logic [31:0] ctr_i,
  input logic        res_valid_o,
  input logic        taken_o,
  input logic [31:0] npc_o,
  input logic        lr_we_o,
  input logic [31:0] lr_wd_o,
  input logic        ctr_we_o,
  input logic [31:0] ctr_wd_o
);
  // R11: a result follows every issue by exactly one cycle
  assert_result_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> res_valid_o);
  assert_no_spurious_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> !res_valid_o);
  // R1/R10: no side effect without a result
  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> (!taken_o && !lr_we_o && !ctr_we_o));
  // R9: link data is the return address
  assert_link_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_we_o && $past(rst_n)) |-> (lr_wd_o == $past(pc_i) + 32'd4));
  // R5: count write-back is a decrement of the presented count
  assert_ctr_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_we_o && $past(rst_n)) |-> (ctr_wd_o == $past(ctr_i) - 32'd1));
  // R7: fall-through address when not taken
  assert_fallthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !taken_o && $past(rst_n)) |-> (npc_o == $past(pc_i) + 32'd4));
  // R8: register targets are word aligned
  assert_reg_target_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && taken_o && $past(rst_n) && $past(insn_i[31:26]) == 6'd19)
      |-> (npc_o[1:0] == 2'b00));
endmodule

bind branch_resolve branch_resolve_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_i    (issue_i),
  .insn_i     (insn_i),
  .pc_i       (pc_i),
  .ctr_i      (ctr_i),
  .res_valid_o(res_valid_o),
  .taken_o    (taken_o),
  .npc_o      (npc_o),
  .lr_we_o    (lr_we_o),
  .lr_wd_o    (lr_wd_o),
  .ctr_we_o   (ctr_we_o),
  .ctr_wd_o   (ctr_wd_o)
);

// File: tb/branch_resolve_bench.sv
module branch_resolve_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct {
    logic        taken;
    logic [31:0] npc;
    logic        lr_we;
    logic [31:0] lr_wd;
    logic        ctr_we;
    logic [31:0] ctr_wd;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [31:0] insn_i = '0, pc_i = '0, cr_i = '0, lr_i = '0, ctr_i = '0;
  logic        res_valid_o, taken_o, lr_we_o, ctr_we_o;
  logic [31:0] npc_o, lr_wd_o, ctr_wd_o;

  int   n_checks = 0;
  int   n_fail = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolve u_branch_resolve (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .insn_i(insn_i), .pc_i(pc_i),
    .cr_i(cr_i), .lr_i(lr_i), .ctr_i(ctr_i), .res_valid_o(res_valid_o),
    .taken_o(taken_o), .npc_o(npc_o), .lr_we_o(lr_we_o), .lr_wd_o(lr_wd_o),
    .ctr_we_o(ctr_we_o), .ctr_wd_o(ctr_wd_o)
  );

  function automatic logic [31:0] f_uncond(int li, bit aa, bit lk);
    return {6'd18, 24'(li), aa, lk};
  endfunction
  function automatic logic [31:0] f_cond(logic [4:0] bo, logic [4:0] bi, int bd, bit aa, bit lk);
    return {6'd16, bo, bi, 14'(bd), aa, lk};
  endfunction
  function automatic logic [31:0] f_reg(logic [4:0] bo, logic [4:0] bi, int xo, bit lk);
    return {6'd19, bo, bi, 5'd0, 10'(xo), lk};
  endfunction

  // Reference model written from the requirements
  function automatic exp_t model(logic [31:0] insn, logic [31:0] pc, logic [31:0] cr,
                                 logic [31:0] lr, logic [31:0] ctr, string tag);
    exp_t e;
    int   op, xo, off;
    bit   cond, known, cnt_ok, bit_ok;
    logic [4:0]  bo, bi;
    logic [31:0] tgt, nc;
    op = int'(insn[31:26]); xo = int'(insn[10:1]);
    bo = insn[25:21]; bi = insn[20:16];
    e.tag = tag; e.lr_we = 0; e.ctr_we = 0; e.lr_wd = pc + 4; e.ctr_wd = ctr - 1;
    known = 1; cond = 1; tgt = pc + 4;
    if (op == 18) begin
      off = int'(insn[25:2]); if (off >= 8388608) off -= 16777216;
      tgt = insn[1] ? 32'(off * 4) : pc + 32'(off * 4); cond = 0;
    end else if (op == 16) begin
      off = int'(insn[15:2]); if (off >= 8192) off -= 16384;
      tgt = insn[1] ? 32'(off * 4) : pc + 32'(off * 4);
    end else if (op == 19 && xo == 16)  tgt = {lr[31:2], 2'b00};
    else if (op == 19 && xo == 528)     tgt = {ctr[31:2], 2'b00};
    else known = 0;
    if (!known) begin
      e.taken = 0; e.npc = pc + 4; return e;
    end
    e.lr_we = insn[0];
    if (!cond) begin
      e.taken = 1; e.npc = tgt; return e;
    end
    if (bo[2]) cnt_ok = 1;
    else begin
      nc = ctr - 1; e.ctr_we = 1;
      cnt_ok = (nc == 0) ? bo[1] : !bo[1];
    end
    bit_ok = bo[4] ? 1'b1 : (((cr >> (31 - int'(bi))) & 32'd1) == {31'd0, bo[3]});
    e.taken = cnt_ok && bit_ok;
    e.npc = e.taken ? tgt : pc + 4;
    return e;
  endfunction

  task automatic drive(logic [31:0] insn, logic [31:0] pc, logic [31:0] cr,
                       logic [31:0] lr, logic [31:0] ctr, string tag);
    insn_i = insn; pc_i = pc; cr_i = cr; lr_i = lr; ctr_i = ctr; issue_i = 1'b1;
    sb.push_back(model(insn, pc, cr, lr, ctr, tag));
    @(negedge clk);
  endtask

  // Monitor: compare each result against the queued expectation
  always @(negedge clk) begin
    if (rst_n && res_valid_o) begin
      n_checks++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected result: valid=1 expected valid=0");
      end else begin
        exp_t e;
        bit bad;
        e = sb.pop_front();
        bad = (taken_o !== e.taken) || (npc_o !== e.npc) || (lr_we_o !== e.lr_we) ||
              (ctr_we_o !== e.ctr_we) || (e.lr_we && lr_wd_o !== e.lr_wd) ||
              (e.ctr_we && ctr_wd_o !== e.ctr_wd);
        if (bad) begin
          n_fail++;
          $display("FAIL %s: got taken=%0b npc=%h lrwe=%0b lr=%h ctrwe=%0b ctr=%h exp taken=%0b npc=%h lrwe=%0b lr=%h ctrwe=%0b ctr=%h",
                   e.tag, taken_o, npc_o, lr_we_o, lr_wd_o, ctr_we_o, ctr_wd_o,
                   e.taken, e.npc, e.lr_we, e.lr_wd, e.ctr_we, e.ctr_wd);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    n_checks++;
    if (res_valid_o !== 1'b0 || taken_o !== 1'b0 || lr_we_o !== 1'b0 || ctr_we_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 in reset: got v=%0b t=%0b lw=%0b cw=%0b expected all 0",
               res_valid_o, taken_o, lr_we_o, ctr_we_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (res_valid_o !== 1'b0 || lr_we_o !== 1'b0 || ctr_we_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 after reset: got v=%0b lw=%0b cw=%0b expected 0", res_valid_o, lr_we_o, ctr_we_o);
    end
    // R2 unconditional forms
    drive(f_uncond(24'h000010, 0, 0), 32'h0000_1000, 0, 0, 7, "R2 rel positive");
    drive(f_uncond(24'hFFFFFF, 0, 0), 32'h0000_1000, 0, 0, 7, "R2 rel minus one word");
    drive(f_uncond(24'h800000, 1, 0), 32'h0000_1000, 0, 0, 7, "R2 abs top bit");
    drive(f_uncond(24'h7FFFFF, 1, 1), 32'h0000_2000, 0, 0, 7, "R2 R9 abs max with link");
    // R3 conditional immediate, always-true options
    drive(f_cond(5'd20, 0, 14'h3FFF, 0, 0), 32'h0000_3000, 0, 0, 9, "R3 rel minus one word");
    drive(f_cond(5'd20, 0, 14'h2000, 1, 0), 32'h0000_3000, 0, 0, 9, "R3 abs top bit");
    drive(f_cond(5'd20, 0, 14'h0100, 0, 0), 32'hFFFF_FF00, 0, 0, 9, "R3 rel wraps");
    // R4 / R6 condition bit only
    drive(f_cond(5'd4, 5'd2, 14'h0010, 0, 0), 32'h100, 32'h0000_0000, 0, 5, "R4 R6 bit clear match");
    drive(f_cond(5'd4, 5'd2, 14'h0010, 0, 0), 32'h100, 32'h2000_0000, 0, 5, "R6 R7 bit set mismatch");
    drive(f_cond(5'd12, 5'd0, 14'h0010, 0, 0), 32'h100, 32'h8000_0000, 0, 5, "R6 select 0 is MSB");
    drive(f_cond(5'd12, 5'd31, 14'h0010, 0, 0), 32'h100, 32'h8000_0000, 0, 5, "R6 select 31 is LSB clear");
    drive(f_cond(5'd12, 5'd31, 14'h0010, 0, 0), 32'h100, 32'h0000_0001, 0, 5, "R6 select 31 is LSB set");
    // R5 counter test
    drive(f_cond(5'd16, 0, 14'h0020, 0, 0), 32'h200, 0, 0, 5, "R5 nonzero taken");
    drive(f_cond(5'd16, 0, 14'h0020, 0, 0), 32'h200, 0, 0, 1, "R5 reaches zero not taken");
    drive(f_cond(5'd16, 0, 14'h0020, 0, 0), 32'h200, 0, 0, 0, "R5 wraps from zero");
    drive(f_cond(5'd18, 0, 14'h0020, 0, 0), 32'h200, 0, 0, 1, "R5 zero wanted taken");
    drive(f_cond(5'd18, 0, 14'h0020, 0, 0), 32'h200, 0, 0, 3, "R5 zero wanted not taken");
    drive(f_cond(5'd0, 5'd5, 14'h0020, 0, 1), 32'h200, 32'h0400_0000, 0, 5, "R7 R9 R5 cond fails link kept");
    drive(f_cond(5'd8, 5'd5, 14'h0020, 0, 0), 32'h200, 32'h0400_0000, 0, 5, "R7 both pass");
    // R8 register targets
    drive(f_reg(5'd20, 0, 16, 0), 32'h500, 0, 32'h0000_2003, 32'h0000_4001, "R8 to link reg");
    drive(f_reg(5'd20, 0, 16, 1), 32'h500, 0, 32'h0000_2003, 32'h0000_4001, "R8 R9 link reg with link");
    drive(f_reg(5'd20, 0, 528, 0), 32'h500, 0, 32'h0000_2003, 32'h0000_4002, "R8 to count reg");
    drive(f_reg(5'd18, 0, 16, 0), 32'h500, 0, 32'h0000_2000, 32'h0000_0002, "R8 R5 link reg counter fails");
    // R10 unrecognised
    drive(f_reg(5'd0, 0, 17, 1), 32'h600, 0, 32'h0000_2000, 32'h3, "R10 other extended opcode");
    drive({6'd31, 26'h3FF_FFFF}, 32'h600, 0, 0, 3, "R10 other primary opcode");
    issue_i = 1'b0;
    // R11 idle gap, then a single issue
    repeat (3) @(negedge clk);
    drive(f_uncond(24'h000001, 0, 0), 32'h700, 0, 0, 0, "R11 after gap");
    issue_i = 1'b0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R11 results missing: got %0d pending expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule